// File: doc/BRIEF.md
# Weight-Stationary Systolic Convolution Array

This block computes a three-tap one-dimensional convolution over a stream of signed samples. It uses a linear chain of three processing cells. Each cell keeps one coefficient in its own register. Samples and partial sums march through the chain in the same direction, and move only on the clock edges at which an input sample is accepted. The sample path has two registers per cell and the partial-sum path has one. Because of this, every partial sum meets, in each cell, exactly the sample it needs. No adder tree ever sees more than one product.

Coefficients are written one at a time through a load strobe with a small index, while the stream is idle. After that, samples are presented with a valid flag. For every accepted sample once the chain is full, the array returns one completed sum, flagged valid for a single cycle. The sum is widened so that three full-scale products cannot overflow.

The cell where partial sums enter holds the last coefficient, and the cell that delivers results holds the first. This reversed placement is what lets a slower sample path line up with a faster sum path.

Top module: `sconv3_array`

## Requirements
- R1: A synchronous active-high reset clears every coefficient, every pipeline register and every valid flag. In the cycle after reset, `out_valid` is 0 and `out_y` is 0.
- R2: A cycle with `wt_ld` high writes `wt_val` into coefficient w(k+1), where k is the value of `wt_idx`: index 0 writes w1, index 1 writes w2 and index 2 writes w3. A load with index 3 changes no coefficient.
- R3: With x(n) the n-th accepted sample counted from reset, result number k equals w1·x(k) + w2·x(k+1) + w3·x(k+2). The result is exact as a 34-bit two's-complement value, including for samples and coefficients of -32768 and 32767.
- R4: Results leave in order k = 1, 2, 3, …, one result for each accepted sample once the chain is full.
- R5: `out_valid` is high only in the cycle that directly follows an accepting edge, and only for one cycle. The first four accepted samples produce no valid output. Result k is presented in the cycle after the edge that accepts sample x(k+4). In a gapless stream, this is two cycles after x(k+2) is accepted.
- R6: A cycle with `in_valid` low moves nothing. `out_valid` is 0 in the following cycle, `out_y` keeps its last value, and the pairing of later samples and sums is undisturbed.
- R7: A reset in the middle of a stream discards all partial sums. After the coefficients are loaded again, the first valid result again needs five fresh samples and uses only those samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wt_ld | input | 1 | Coefficient write strobe |
| wt_idx | input | 2 | Coefficient index: 0 is w1, 1 is w2, 2 is w3, 3 is ignored |
| wt_val | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Input sample is present and accepted this cycle |
| in_x | input | 16 | Signed input sample |
| out_valid | output | 1 | `out_y` holds a new completed result |
| out_y | output | 34 | Signed convolution result |

## Verification
The assertions assume that coefficients are written only while no sample is being accepted. They also assume that a fresh stream is preceded by a reset, so that no partial sum in flight mixes old and new coefficients. The stimulus keeps to this: it resets the array before each change of coefficients and issues loads only in cycles with `in_valid` low. Within a stream, valid samples are mixed freely with idle cycles, full-scale negative and positive values, and a reset part-way through a stream.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

  // Bits needed to address n entries (at least one).
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Growth bits needed to add n products without overflow.
  function automatic int growth_bits(input int n);
    return (n < 2) ? 0 : $clog2(n);
  endfunction

endpackage

// File: rtl/sconv_wbank.sv
module sconv_wbank #(
  parameter int TAPS = 3,
  parameter int WW   = 16,
  parameter int IW   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_en,
  input  logic [IW-1:0]            ld_idx,
  input  logic [WW-1:0]            ld_val,
  output logic [TAPS-1:0][WW-1:0]  wt
);

  for (genvar k = 0; k < TAPS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        wt[k] <= '0;
      end else if (ld_en && (ld_idx == IW'(k))) begin
        wt[k] <= ld_val;
      end
    end
  end

  // R2: an index beyond the last tap leaves every coefficient untouched
  assert_bad_index_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (ld_en && (int'(ld_idx) >= TAPS)) |=> $stable(wt));

endmodule

// File: rtl/sconv_cell.sv
module sconv_cell #(
  parameter int DW = 16,
  parameter int WW = 16,
  parameter int AW = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [WW-1:0] wt,
  input  logic signed [DW-1:0] x_in,
  input  logic                 xv_in,
  input  logic signed [AW-1:0] s_in,
  input  logic                 sv_in,
  output logic signed [DW-1:0] x_out,
  output logic                 xv_out,
  output logic signed [AW-1:0] s_out,
  output logic                 sv_out
);

  localparam int PW = DW + WW;

  logic signed [DW-1:0] x_mid;
  logic                 xv_mid;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_next;
  logic signed [AW:0]   acc_wide;

  always_comb begin
    prod     = wt * x_in;
    acc_next = s_in + {{(AW-PW){prod[PW-1]}}, prod};
    acc_wide = {s_in[AW-1], s_in} + {{(AW+1-PW){prod[PW-1]}}, prod};
  end

  // Sample path: two registers per cell. Sum path: one register per cell.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_mid  <= '0;
      xv_mid <= 1'b0;
      x_out  <= '0;
      xv_out <= 1'b0;
      s_out  <= '0;
      sv_out <= 1'b0;
    end else if (step) begin
      x_mid  <= x_in;
      xv_mid <= xv_in;
      x_out  <= x_mid;
      xv_out <= xv_mid;
      s_out  <= acc_next;
      sv_out <= sv_in & xv_in;
    end
  end

  // R3: accumulating one more product never leaves the widened range
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    step |-> (acc_wide[AW] == acc_wide[AW-1]));

  // R6: an idle cycle freezes both the sample and the sum held by the cell
  assert_cell_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(s_out) && $stable(x_out) && $stable(sv_out)));

endmodule

// File: rtl/sconv3_array.sv
module sconv3_array
  import sconv_pkg::*;
#(
  parameter int DW   = 16,
  parameter int WW   = 16,
  parameter int TAPS = 3,
  localparam int IW  = idx_bits(TAPS),
  localparam int AW  = DW + WW + growth_bits(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wt_ld,
  input  logic [IW-1:0] wt_idx,
  input  logic [WW-1:0] wt_val,
  input  logic          in_valid,
  input  logic [DW-1:0] in_x,
  output logic          out_valid,
  output logic [AW-1:0] out_y
);

  localparam int FILL = 2 * TAPS - 1;
  localparam int CW   = $clog2(FILL + 1);

  logic [TAPS-1:0][WW-1:0] wt_flat;
  logic [TAPS:0][DW-1:0]   x_link;
  logic [TAPS:0]           xv_link;
  logic [TAPS:0][AW-1:0]   s_link;
  logic [TAPS:0]           sv_link;

  sconv_wbank #(.TAPS(TAPS), .WW(WW), .IW(IW)) u_wbank (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (wt_ld),
    .ld_idx (wt_idx),
    .ld_val (wt_val),
    .wt     (wt_flat)
  );

  assign x_link[0]  = in_x;
  assign xv_link[0] = 1'b1;
  assign s_link[0]  = '0;
  assign sv_link[0] = 1'b1;

  // Cell c holds coefficient number TAPS-c, so the sum-entry cell holds the last one.
  for (genvar c = 0; c < TAPS; c++) begin : g_cell
    sconv_cell #(.DW(DW), .WW(WW), .AW(AW)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .step   (in_valid),
      .wt     (wt_flat[TAPS-1-c]),
      .x_in   (x_link[c]),
      .xv_in  (xv_link[c]),
      .s_in   (s_link[c]),
      .sv_in  (sv_link[c]),
      .x_out  (x_link[c+1]),
      .xv_out (xv_link[c+1]),
      .s_out  (s_link[c+1]),
      .sv_out (sv_link[c+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid & sv_link[TAPS-1] & xv_link[TAPS-1];
    end
  end

  assign out_y = s_link[TAPS];

  // Checker-side count of accepted samples, saturating at the fill depth.
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
    end else if (in_valid && (seen_q != CW'(FILL))) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R1: reset leaves no valid result behind
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R5: a result is flagged only right after an accepting edge
  assert_valid_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R5: no result before the chain has taken its fill of samples
  assert_fill_depth_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q == CW'(FILL)));

  // R4: a sample leaving the chain implies the sum beside it is complete
  assert_alignment_R4: assert property (@(posedge clk) disable iff (rst)
    xv_link[TAPS] |-> sv_link[TAPS]);

  // R6: idle input freezes the result and the sample at the chain end
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_y) && $stable(x_link[TAPS])));

endmodule

// File: tb/sconv3_array_tb.sv
`timescale 1ns/1ps
module sconv3_array_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wt_ld;
  logic [1:0]  wt_idx;
  logic [15:0] wt_val;
  logic        in_valid;
  logic [15:0] in_x;
  logic        out_valid;
  logic [33:0] out_y;

  always #5 clk = ~clk;

  sconv3_array u_dut (
    .clk       (clk),
    .rst       (rst),
    .wt_ld     (wt_ld),
    .wt_idx    (wt_idx),
    .wt_val    (wt_val),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_y     (out_y)
  );

  int     vectors = 0;
  int     misses  = 0;
  longint w_m [3];
  longint hist [$];
  bit     exp_valid;
  longint exp_y;
  bit     have_last;
  longint last_y;
  string  req_tag = "R1";
  bit     done = 1'b0;

  task automatic fail_line(input string tag, input longint act, input longint exp);
    misses++;
    $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
  endtask

  task automatic cyc(input bit r, input bit ld, input logic [1:0] idx,
                     input longint wv, input bit iv, input longint xv);
    longint act;
    int n;
    rst      = r;
    wt_ld    = ld;
    wt_idx   = idx;
    wt_val   = 16'(wv);
    in_valid = iv;
    in_x     = 16'(xv);
    if (r) begin
      for (int i = 0; i < 3; i++) w_m[i] = 0;
      hist.delete();
      exp_valid = 1'b0;
      have_last = 1'b0;
    end else begin
      if (ld && idx < 3) w_m[idx] = wv;
      exp_valid = 1'b0;
      if (iv) begin
        hist.push_back(xv);
        n = hist.size();
        if (n >= 5) begin
          exp_valid = 1'b1;
          exp_y = w_m[0]*hist[n-5] + w_m[1]*hist[n-4] + w_m[2]*hist[n-3];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    act = longint'($signed(out_y));
    vectors++;
    if (out_valid !== exp_valid)
      fail_line((req_tag == "R7") ? "R7" : "R5", longint'(out_valid), longint'(exp_valid));
    if (r) begin
      vectors++;
      if (act != 0) fail_line("R1", act, 0);
    end else if (exp_valid) begin
      vectors++;
      if (act != exp_y) fail_line(req_tag, act, exp_y);
      have_last = 1'b1;
      last_y    = exp_y;
    end else if (!iv && have_last) begin
      vectors++;
      if (act != last_y) fail_line("R6", act, last_y);
    end
  endtask

  task automatic load3(input longint a, input longint b, input longint c);
    cyc(0, 1, 2'd0, a, 0, 0);
    cyc(0, 1, 2'd1, b, 0, 0);
    cyc(0, 1, 2'd2, c, 0, 0);
  endtask

  task automatic feed(input longint xv);
    cyc(0, 0, 2'd0, 0, 1, xv);
  endtask

  task automatic do_reset();
    req_tag = "R1";
    cyc(1, 0, 2'd0, 0, 0, 0);
    cyc(1, 0, 2'd0, 0, 0, 0);
  endtask

  initial begin
    logic [7:0] lfsr;
    rst = 1'b1; wt_ld = 1'b0; wt_idx = '0; wt_val = '0; in_valid = 1'b0; in_x = '0;
    do_reset();
    cyc(1, 0, 2'd0, 0, 0, 0);

    // R2: coefficients via index, index 3 ignored; results expose the stored values
    req_tag = "R2";
    load3(3, -5, 7);
    cyc(0, 1, 2'd3, 1234, 0, 0);
    for (int i = 0; i < 10; i++) feed((i * 37) % 100 - 50);

    // R4: long gapless run, one ordered result per sample
    req_tag = "R4";
    for (int i = 0; i < 12; i++) feed(1000 - i * 173);

    // R3: full-scale negative values everywhere
    do_reset();
    req_tag = "R3";
    load3(-32768, -32768, -32768);
    for (int i = 0; i < 7; i++) feed(-32768);
    for (int i = 0; i < 6; i++) feed(32767);

    // R3: mixed extremes with alternating sign
    do_reset();
    req_tag = "R3";
    load3(32767, -32768, 32767);
    for (int i = 0; i < 12; i++) feed((i % 2 == 0) ? -32768 : 32767);

    // R6: irregular gaps in the stream
    do_reset();
    req_tag = "R6";
    load3(-2, 9, -4);
    lfsr = 8'hA5;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(0, 0, 2'd0, 0, lfsr[0] | lfsr[3], longint'(i * 211 % 3001) - 1500);
    end

    // R7: reset part-way through a stream, then a fresh fill
    req_tag = "R7";
    for (int i = 0; i < 3; i++) feed(77 + i);
    cyc(1, 0, 2'd0, 0, 0, 0);
    load3(5, 6, -7);
    for (int i = 0; i < 8; i++) feed(i * 11 - 40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule